// File: doc/BRIEF.md
# Automatic Tea Brewing Sequencer

This block is a synchronous controller for an automatic tea maker. A daily time switch starts a brew cycle. The controller opens the inlet valve so the kettle fills. When the float switch reports the kettle full, it turns the heating element on. When the boil thermostat trips, it opens the outlet valve to pour into the teapot. When the teapot-full sensor fires, it rings the alarm bell. The bell keeps ringing until the user acknowledges it.

Each phase is ended by its own sensor and hands straight over to the next actuator on the same clock edge. At most one actuator drive is active at any time. All five switch inputs pass through a two-flop synchronizer inside the block. A cycle starts only on a rising edge of the synchronized time switch seen while idle, so a switch left closed cannot start a second brew.

Top module: `brew_sequencer`

## Requirements
- R1: The active-high synchronous reset `rst` puts the controller in idle with `fill_valve`, `heater`, `pour_valve` and `bell` all low; the outputs read low on the clock edge after reset is sampled.
- R2: While idle, a low-to-high change of the synchronized `time_sw` starts a cycle, and `fill_valve` goes high.
- R3: A `time_sw` that stays high after a cycle ends does not start another cycle. A rising edge of `time_sw` that occurs while a cycle is running is dropped.
- R4: `fill_valve` stays high until `float_sw` is seen. On that edge `fill_valve` falls and `heater` rises.
- R5: `heater` stays high until `boil_sw` is seen. On that edge `heater` falls and `pour_valve` rises.
- R6: `pour_valve` stays high until `pot_full` is seen. On that edge `pour_valve` falls and `bell` rises.
- R7: `bell` stays high until `alarm_ack` is seen. On that edge `bell` falls and the controller returns to idle.
- R8: At most one of the four outputs is high in any cycle.
- R9: Each input acts on the outputs at the third rising clock edge after the input changes (two synchronizer flops, then the registered state and outputs). The outputs are unchanged at the second edge.
- R10: If the sensor that ends a phase is already high when that phase is entered, the phase lasts exactly one clock cycle.
- R11: A sensor or acknowledge that belongs to a different phase has no effect on the current phase or its output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| time_sw | input | 1 | Daily time switch, asynchronous |
| float_sw | input | 1 | Kettle float switch, high when the kettle is full |
| boil_sw | input | 1 | Boil thermostat, high when the water boils |
| pot_full | input | 1 | Teapot-full sensor |
| alarm_ack | input | 1 | User acknowledge of the bell |
| fill_valve | output | 1 | Inlet valve drive (kettle fill) |
| heater | output | 1 | Heating element drive |
| pour_valve | output | 1 | Outlet valve drive (teapot pour) |
| bell | output | 1 | Alarm bell drive |

## Verification
Every input change is due at the outputs at the third rising edge after it is driven. A phase whose sensor is already high at entry hands over one edge later than the phase before it. The bench drives stimulus just after a falling edge. For each stimulus it queues the output word expected at a given future cycle count, including the unchanged word at the second edge. A monitor compares that word on the falling edge of the due cycle, so every comparison samples the registered outputs well after they have settled.

// File: rtl/brew_pkg.sv
package brew_pkg;

  localparam int NUM_STOP = 4;  // one ending sensor per active phase

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_FILL  = 3'd1,
    PH_HEAT  = 3'd2,
    PH_POUR  = 3'd3,
    PH_ALERT = 3'd4
  } phase_t;

  typedef struct packed {
    logic fill_valve;
    logic heater;
    logic pour_valve;
    logic bell;
  } drive_t;

  // Actuator word owned by a phase; idle drives nothing.
  function automatic drive_t drive_of(phase_t p);
    drive_t d;
    d = '0;
    case (p)
      PH_FILL:  d.fill_valve = 1'b1;
      PH_HEAT:  d.heater     = 1'b1;
      PH_POUR:  d.pour_valve = 1'b1;
      PH_ALERT: d.bell       = 1'b1;
      default:  d = '0;
    endcase
    return d;
  endfunction

  // stop[0]=kettle full, stop[1]=boiling, stop[2]=pot full, stop[3]=ack
  function automatic phase_t next_phase(phase_t p, logic start,
                                        logic [NUM_STOP-1:0] stop);
    phase_t n;
    n = p;
    case (p)
      PH_IDLE:  if (start)   n = PH_FILL;
      PH_FILL:  if (stop[0]) n = PH_HEAT;
      PH_HEAT:  if (stop[1]) n = PH_POUR;
      PH_POUR:  if (stop[2]) n = PH_ALERT;
      PH_ALERT: if (stop[3]) n = PH_IDLE;
      default:  n = PH_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/brew_sync.sv
module brew_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  localparam int TOP = STAGES - 1;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_async[i]};
      end
      assign q_sync[i] = chain[TOP];
    end
  endgenerate
endmodule

// File: rtl/brew_edge.sv
module brew_edge (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= level;
  end

  assign rise = level & ~prev;
endmodule

// File: rtl/brew_fsm.sv
module brew_fsm
  import brew_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [NUM_STOP-1:0] stop,
  output phase_t              phase,
  output drive_t              drive
);
  phase_t phase_nxt;

  assign phase_nxt = next_phase(phase, start, stop);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      drive <= '0;
    end else begin
      phase <= phase_nxt;
      drive <= drive_of(phase_nxt);
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (phase == PH_IDLE && drive == '0));

  assert_start_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && start) |=> phase == PH_FILL);

  assert_stay_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && !start) |=> (phase == PH_IDLE && drive == '0));

  assert_ack_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ALERT && stop[3]) |=> (phase == PH_IDLE && drive == '0));

  assert_short_fill_R10: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FILL && stop[0]) |=> phase == PH_HEAT);

  assert_hold_heat_R11: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HEAT && !stop[1]) |=> phase == PH_HEAT);
endmodule

// File: rtl/brew_sequencer.sv
module brew_sequencer
  import brew_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic time_sw,
  input  logic float_sw,
  input  logic boil_sw,
  input  logic pot_full,
  input  logic alarm_ack,
  output logic fill_valve,
  output logic heater,
  output logic pour_valve,
  output logic bell
);
  localparam int NUM_IN = NUM_STOP + 1;

  logic [NUM_IN-1:0] raw_in;
  logic [NUM_IN-1:0] sync_in;
  logic              start_evt;
  phase_t            phase;
  drive_t            drive;

  assign raw_in = {alarm_ack, pot_full, boil_sw, float_sw, time_sw};

  brew_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (raw_in),
    .q_sync  (sync_in)
  );

  brew_edge u_edge (
    .clk   (clk),
    .rst   (rst),
    .level (sync_in[0]),
    .rise  (start_evt)
  );

  brew_fsm u_fsm (
    .clk   (clk),
    .rst   (rst),
    .start (start_evt),
    .stop  (sync_in[NUM_IN-1:1]),
    .phase (phase),
    .drive (drive)
  );

  assign fill_valve = drive.fill_valve;
  assign heater     = drive.heater;
  assign pour_valve = drive.pour_valve;
  assign bell       = drive.bell;

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fill_valve, heater, pour_valve, bell}));

  assert_fill_to_heat_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(fill_valve)) |-> heater);

  assert_heat_to_pour_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(heater)) |-> pour_valve);

  assert_pour_to_bell_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(pour_valve)) |-> bell);
endmodule

// File: tb/sim_brew_sequencer.sv
module sim_brew_sequencer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic time_sw = 1'b0, float_sw = 1'b0, boil_sw = 1'b0;
  logic pot_full = 1'b0, alarm_ack = 1'b0;
  logic fill_valve, heater, pour_valve, bell;

  int cyc = 0;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    int       due;
    logic [3:0] word;
    string    req;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  brew_sequencer u0 (
    .clk(clk), .rst(rst), .time_sw(time_sw), .float_sw(float_sw),
    .boil_sw(boil_sw), .pot_full(pot_full), .alarm_ack(alarm_ack),
    .fill_valve(fill_valve), .heater(heater), .pour_valve(pour_valve),
    .bell(bell)
  );

  function automatic logic [3:0] outs();
    return {fill_valve, heater, pour_valve, bell};
  endfunction

  task automatic check_now(logic [3:0] exp, string req);
    tests++;
    if (outs() !== exp) begin
      fails++;
      $display("FAIL %s: outputs %b expected %b at cycle %0d", req, outs(), exp, cyc);
    end
  endtask

  // Driver side: queue the word due d cycles from now.
  task automatic expect_in(int d, logic [3:0] w, string req);
    exp_t e;
    e.due = cyc + d; e.word = w; e.req = req;
    sb.push_back(e);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare due entries, and exclusivity every cycle.
  always @(negedge clk) begin
    if (!rst) begin
      tests++;
      if ($countones(outs()) > 1) begin
        fails++;
        $display("FAIL R8: outputs %b expected at most one high", outs());
      end
    end
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        check_now(sb[i].word, sb[i].req);
        sb.delete(i);
      end
    end
  end

  initial begin
    wait_cyc(3);
    check_now(4'b0000, "R1 reset state");
    rst = 1'b0;
    wait_cyc(2);

    // Full cycle with one sensor at a time
    time_sw = 1'b1;
    expect_in(2, 4'b0000, "R9 not yet");
    expect_in(3, 4'b1000, "R2 start fill");
    wait_cyc(5);
    float_sw = 1'b1;
    expect_in(2, 4'b1000, "R9 fill held");
    expect_in(3, 4'b0100, "R4 fill to heat");
    wait_cyc(5);
    float_sw = 1'b0;
    boil_sw = 1'b1;
    expect_in(3, 4'b0010, "R5 heat to pour");
    wait_cyc(5);
    boil_sw = 1'b0;
    pot_full = 1'b1;
    expect_in(3, 4'b0001, "R6 pour to bell");
    wait_cyc(5);
    pot_full = 1'b0;
    alarm_ack = 1'b1;
    expect_in(2, 4'b0001, "R7 bell held");
    expect_in(3, 4'b0000, "R7 ack to idle");
    wait_cyc(4);
    alarm_ack = 1'b0;
    expect_in(6, 4'b0000, "R3 held switch no restart");
    wait_cyc(8);

    // Out-of-phase sensors, then sensors already high at phase entry
    time_sw = 1'b0;
    wait_cyc(4);
    time_sw = 1'b1;
    expect_in(3, 4'b1000, "R2 second start");
    wait_cyc(5);
    boil_sw = 1'b1; pot_full = 1'b1; alarm_ack = 1'b1;
    expect_in(4, 4'b1000, "R11 foreign sensors ignored");
    wait_cyc(6);
    alarm_ack = 1'b0;
    wait_cyc(3);
    float_sw = 1'b1;
    expect_in(3, 4'b0100, "R4 fill to heat");
    expect_in(4, 4'b0010, "R10 one-cycle heat");
    expect_in(5, 4'b0001, "R10 one-cycle pour");
    wait_cyc(7);
    float_sw = 1'b0; boil_sw = 1'b0; pot_full = 1'b0;
    alarm_ack = 1'b1;
    expect_in(3, 4'b0000, "R7 ack to idle");
    wait_cyc(5);
    alarm_ack = 1'b0;

    // Reset in the middle of a phase
    time_sw = 1'b0;
    wait_cyc(4);
    time_sw = 1'b1;
    wait_cyc(5);
    float_sw = 1'b1;
    wait_cyc(5);
    check_now(4'b0100, "R4 heating before reset");
    time_sw = 1'b0;
    rst = 1'b1;
    expect_in(1, 4'b0000, "R1 mid-phase reset");
    wait_cyc(2);
    rst = 1'b0;
    float_sw = 1'b0;
    expect_in(6, 4'b0000, "R1 stays idle");
    wait_cyc(8);

    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R9: %0d expectations never compared, expected 0", sb.size());
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run still busy at cycle %0d, expected finished", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule